// File: doc/BRIEF.md
# Frame-Referenced Lane Aligner and Sample Builder

This block sits after a 1:8 deserializer on a multi-channel serial ADC link. Each word clock it takes an 8-bit word from the two data lanes of every channel and from two frame lanes. Each frame lane carries a fixed reference pattern. For each frame domain a small controller compares the frame word with the expected pattern. On a mismatch it sends one-cycle bit-slip requests back to the deserializer, and it waits a settle time after each request. It declares the domain aligned once the pattern has been seen on several consecutive words.

Once a domain is aligned, the block rebuilds each of its channels' samples. Lane A holds the odd data bits and lane B the even ones, with the first received bit in each word's MSB. The two lanes are woven into a 16-bit word: 14 data bits above two zero bits. The sample is marked valid only while its domain holds alignment. If a domain fails to align within a bounded number of slips, it raises a fail flag and keeps searching. Losing the pattern later drops alignment and restarts the search.

Top module: `frame_lane_aligner`

## Requirements
- R1: One word clock after the lane words are presented, `sample_words` for channel c holds lane A bit k at sample bit 2k+1 and lane B bit k at sample bit 2k, for k = 1..7. Lane bit 7 is the first received bit.
- R2: Sample bits [1:0] are always 0, whatever the lanes carry in their bit 0.
- R3: A slip request is a single-cycle pulse on the domain's bit of `slip_req`. It is raised only after a frame-word mismatch during search. Two pulses on one domain are at least SETTLE+1 (default 5) cycles apart.
- R4: Out of reset all outputs are 0. While `rx_locked` is low, no slip is requested and no domain reports aligned or fail.
- R5: A domain becomes aligned after its frame word has equalled PATTERN (default 8'hF0) on MATCHES (default 4) consecutive compared words. Starting from a boundary offset of o bits, exactly (8-o) mod 8 slips are issued before alignment.
- R6: Bit 0 of `slip_req`, `aligned` and `align_fail` belongs to frame A, which governs channels 1, 4, 5 and 8 (indices 0, 3, 4, 7). Bit 1 belongs to frame B, which governs channels 2, 3, 6 and 7 (indices 1, 2, 5, 6). The two domains search independently.
- R7: If MAX_SLIPS (default 8) slips pass without alignment, `align_fail` rises in the same cycle as the 8th pulse. Slipping then continues, and `align_fail` clears when alignment is reached.
- R8: While aligned, a single frame-word mismatch clears `aligned` on the next cycle, and the domain resumes slipping.
- R9: `sample_valid` for a channel is 1 exactly one cycle after its domain reports aligned, and it is 0 one cycle after the domain loses alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_locked | input | 1 | Receiver PLL lock; the search is held off while low |
| frame_a_word | input | 8 | Deserialized frame lane, domain A |
| frame_b_word | input | 8 | Deserialized frame lane, domain B |
| lane_a_words | input | 64 | Odd-bit lane word per channel, channel c at [8c+7:8c] |
| lane_b_words | input | 64 | Even-bit lane word per channel, channel c at [8c+7:8c] |
| sample_words | output | 128 | Assembled 16-bit sample per channel, channel c at [16c+15:16c] |
| sample_valid | output | 8 | Per-channel sample valid |
| slip_req | output | 2 | Bit-slip pulse per domain (bit 0 = A) |
| aligned | output | 2 | Domain aligned flag, 1 = success |
| align_fail | output | 2 | Domain failed to align within MAX_SLIPS |

## Verification
Two functions can fall in the same cycle: one domain re-searching and slipping while the other domain delivers valid samples. The bench provokes this by jumping domain A's modelled bit offset without a slip while both domains are aligned. In every following cycle it checks that frame A's channels lose valid one cycle after `aligned[0]` drops, and that A issues exactly the expected number of slips. Over the same cycles, frame B's channels must keep valid samples equal to their interleaved lane contents, and `slip_req[1]` must stay low.

// File: rtl/fla_pkg.sv
package fla_pkg;

  localparam int unsigned LANE_W   = 8;
  localparam int unsigned SAMPLE_W = 2 * LANE_W;

  typedef enum logic [1:0] {
    LK_HUNT = 2'd0,
    LK_WAIT = 2'd1,
    LK_LOCK = 2'd2
  } lock_state_e;

  // Weave odd-bit and even-bit lane words into one sample; pad bits forced to 0.
  function automatic logic [SAMPLE_W-1:0] weave(input logic [LANE_W-1:0] odd_w,
                                                input logic [LANE_W-1:0] even_w);
    logic [SAMPLE_W-1:0] r;
    for (int k = 0; k < LANE_W; k++) begin
      r[2*k+1] = odd_w[k];
      r[2*k]   = even_w[k];
    end
    r[1:0] = 2'b00;
    return r;
  endfunction

endpackage

// File: rtl/fla_lock_ctrl.sv
module fla_lock_ctrl #(
  parameter int unsigned     W         = 8,
  parameter logic [W-1:0]    PATTERN   = 8'hF0,
  parameter int unsigned     MATCHES   = 4,
  parameter int unsigned     SETTLE    = 4,
  parameter int unsigned     MAX_SLIPS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pll_locked,
  input  logic [W-1:0] frame_word,
  output logic         slip_req,
  output logic         aligned,
  output logic         align_fail
);
  import fla_pkg::*;

  localparam int unsigned MW = $clog2(MATCHES + 1);
  localparam int unsigned SW = $clog2(SETTLE + 1);
  localparam int unsigned KW = $clog2(MAX_SLIPS + 1);

  lock_state_e   state;
  logic [MW-1:0] match_cnt;
  logic [SW-1:0] wait_cnt;
  logic [KW-1:0] slip_cnt;

  // Named events for the assertions
  wire frame_hit  = (frame_word == PATTERN);
  wire last_match = (match_cnt == MW'(MATCHES - 1));
  wire slip_fire  = (state == LK_HUNT) && !frame_hit;
  wire lock_lost  = (state == LK_LOCK) && !frame_hit;
  wire slips_out  = (slip_cnt == KW'(MAX_SLIPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !pll_locked) begin
      state      <= LK_HUNT;
      match_cnt  <= '0;
      wait_cnt   <= '0;
      slip_cnt   <= '0;
      slip_req   <= 1'b0;
      aligned    <= 1'b0;
      align_fail <= 1'b0;
    end else begin
      slip_req <= slip_fire;
      case (state)
        LK_HUNT: begin
          if (frame_hit) begin
            if (last_match) begin
              state      <= LK_LOCK;
              aligned    <= 1'b1;
              align_fail <= 1'b0;
              match_cnt  <= '0;
              slip_cnt   <= '0;
            end else begin
              match_cnt <= match_cnt + 1'b1;
            end
          end else begin
            match_cnt <= '0;
            state     <= LK_WAIT;
            wait_cnt  <= SW'(SETTLE - 1);
            if (slips_out) begin
              align_fail <= 1'b1;
              slip_cnt   <= '0;
            end else begin
              slip_cnt <= slip_cnt + 1'b1;
            end
          end
        end
        LK_WAIT: begin
          if (wait_cnt == '0) state <= LK_HUNT;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        LK_LOCK: begin
          if (lock_lost) begin
            aligned <= 1'b0;
            state   <= LK_HUNT;
          end
        end
        default: state <= LK_HUNT;
      endcase
    end
  end

  // Cycles since the last slip pulse, saturating, for the spacing check
  logic [SW-1:0] gap_cnt;
  logic          gap_seen;
  always_ff @(posedge clk) begin
    if (!rst_n || !pll_locked) begin
      gap_cnt  <= '0;
      gap_seen <= 1'b0;
    end else if (slip_req) begin
      gap_cnt  <= '0;
      gap_seen <= 1'b1;
    end else if (gap_cnt != SW'(SETTLE)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_req |=> !slip_req); // R3
  AST_SLIP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_req && gap_seen) |-> (gap_cnt == SW'(SETTLE))); // R3
  AST_NO_SLIP_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (!slip_req && !aligned && !align_fail)); // R4
  AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(frame_hit)); // R5
  AST_ALIGNED_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> !slip_req); // R5
  AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n || !pll_locked)
    (aligned && !frame_hit) |=> !aligned); // R8
  AST_FAIL_NOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    align_fail |-> !aligned); // R7

endmodule

// File: rtl/fla_sample_pack.sv
module fla_sample_pack #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   odd_lane,
  input  logic [W-1:0]   even_lane,
  input  logic           dom_aligned,
  output logic [2*W-1:0] sample,
  output logic           valid
);
  import fla_pkg::*;

  wire [2*W-1:0] woven = weave(odd_lane, even_lane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample <= '0;
      valid  <= 1'b0;
    end else begin
      sample <= woven;
      valid  <= dom_aligned;
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sample[1:0] == 2'b00); // R2
  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_aligned) |=> !valid); // R9

endmodule

// File: rtl/frame_lane_aligner.sv
module frame_lane_aligner #(
  parameter int unsigned        NUM_CH     = 8,
  parameter int unsigned        LANE_W     = 8,
  parameter logic [LANE_W-1:0]  PATTERN    = 8'hF0,
  parameter int unsigned        MATCHES    = 4,
  parameter int unsigned        SETTLE     = 4,
  parameter int unsigned        MAX_SLIPS  = 8,
  parameter logic [NUM_CH-1:0]  DOM_B_MASK = 8'b0110_0110
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_locked,
  input  logic [LANE_W-1:0]            frame_a_word,
  input  logic [LANE_W-1:0]            frame_b_word,
  input  logic [NUM_CH*LANE_W-1:0]     lane_a_words,
  input  logic [NUM_CH*LANE_W-1:0]     lane_b_words,
  output logic [NUM_CH*2*LANE_W-1:0]   sample_words,
  output logic [NUM_CH-1:0]            sample_valid,
  output logic [1:0]                   slip_req,
  output logic [1:0]                   aligned,
  output logic [1:0]                   align_fail
);
  localparam int unsigned NUM_DOM = 2;
  localparam int unsigned SMP_W   = 2 * LANE_W;

  logic [LANE_W-1:0] frame_words [NUM_DOM];
  assign frame_words[0] = frame_a_word;
  assign frame_words[1] = frame_b_word;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    fla_lock_ctrl #(
      .W(LANE_W), .PATTERN(PATTERN), .MATCHES(MATCHES),
      .SETTLE(SETTLE), .MAX_SLIPS(MAX_SLIPS)
    ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .pll_locked (rx_locked),
      .frame_word (frame_words[d]),
      .slip_req   (slip_req[d]),
      .aligned    (aligned[d]),
      .align_fail (align_fail[d])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned DOM = DOM_B_MASK[c] ? 1 : 0;

    fla_sample_pack #(.W(LANE_W)) i_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .odd_lane    (lane_a_words[c*LANE_W +: LANE_W]),
      .even_lane   (lane_b_words[c*LANE_W +: LANE_W]),
      .dom_aligned (aligned[DOM]),
      .sample      (sample_words[c*SMP_W +: SMP_W]),
      .valid       (sample_valid[c])
    );

    AST_VALID_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid[c] |-> !slip_req[DOM]); // R9
  end

endmodule

// File: tb/test_frame_lane_aligner.sv
module test_frame_lane_aligner;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic          rst_n = 1'b0;
  logic          rx_locked = 1'b0;
  logic [7:0]    frame_a_word, frame_b_word;
  logic [63:0]   lane_a_words, lane_b_words;
  logic [127:0]  sample_words;
  logic [7:0]    sample_valid;
  logic [1:0]    slip_req, aligned, align_fail;

  frame_lane_aligner i_frame_lane_aligner (
    .clk(clk), .rst_n(rst_n), .rx_locked(rx_locked),
    .frame_a_word(frame_a_word), .frame_b_word(frame_b_word),
    .lane_a_words(lane_a_words), .lane_b_words(lane_b_words),
    .sample_words(sample_words), .sample_valid(sample_valid),
    .slip_req(slip_req), .aligned(aligned), .align_fail(align_fail)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Behavioural deserializer: per-domain boundary offset, lane contents per channel
  int         off [2];
  bit         stuck [2];
  logic [15:0] smp [8];
  bit         junk_lsb = 0;
  int         slips_seen [2];
  int         last_slip [2];
  int         min_gap [2];
  int         cyc = 0;

  function automatic logic [7:0] rotl(input logic [7:0] w, input int k);
    logic [15:0] dbl = {w, w};
    return dbl[(8 - (k % 8)) +: 8];
  endfunction

  function automatic int dom_of(input int ch);
    return (ch == 1 || ch == 2 || ch == 5 || ch == 6) ? 1 : 0;
  endfunction

  always_comb begin
    frame_a_word = stuck[0] ? 8'h00 : rotl(8'hF0, off[0]);
    frame_b_word = stuck[1] ? 8'h00 : rotl(8'hF0, off[1]);
    for (int ch = 0; ch < 8; ch++) begin
      logic [7:0] aw, bw;
      for (int k = 1; k < 8; k++) begin
        aw[k] = smp[ch][2*k+1];
        bw[k] = smp[ch][2*k];
      end
      aw[0] = junk_lsb;
      bw[0] = junk_lsb;
      lane_a_words[ch*8 +: 8] = rotl(aw, off[dom_of(ch)]);
      lane_b_words[ch*8 +: 8] = rotl(bw, off[dom_of(ch)]);
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int d = 0; d < 2; d++) begin
      if (slip_req[d]) begin
        off[d] = (off[d] + 1) % 8;
        slips_seen[d]++;
        if (last_slip[d] >= 0 && (cyc - last_slip[d]) < min_gap[d])
          min_gap[d] = cyc - last_slip[d];
        last_slip[d] = cyc;
      end
    end
    if (cyc > 150000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_mon();
    for (int d = 0; d < 2; d++) begin
      slips_seen[d] = 0; last_slip[d] = -1; min_gap[d] = 1000;
    end
  endtask

  task automatic wait_aligned(input int d, input int limit);
    for (int i = 0; i < limit && !aligned[d]; i++) step(1);
  endtask

  task automatic t_reset();
    rst_n = 0; rx_locked = 0;
    step(3);
    check(slip_req == 0 && aligned == 0 && align_fail == 0 && sample_valid == 0
          && sample_words == 0, "R4", "reset outputs",
          {slip_req, aligned, align_fail, sample_valid}, 0);
  endtask

  task automatic t_hold_unlocked();
    bit any = 0;
    off[0] = 3; off[1] = 6;
    rst_n = 1;
    clear_mon();
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (slip_req != 0 || aligned != 0 || align_fail != 0) any = 1;
    end
    check(!any && slips_seen[0] == 0, "R4", "no search while rx_locked low",
          slips_seen[0] + slips_seen[1], 0);
  endtask

  task automatic t_initial_align();
    clear_mon();
    rx_locked = 1;
    wait_aligned(0, 300);
    wait_aligned(1, 300);
    check(aligned == 2'b11, "R5", "both domains aligned", aligned, 3);
    check(slips_seen[0] == 5, "R5", "slips domain A from offset 3", slips_seen[0], 5);
    check(slips_seen[1] == 2, "R6", "slips domain B from offset 6", slips_seen[1], 2);
    check(min_gap[0] >= 5, "R3", "slip spacing domain A", min_gap[0], 5);
    check(align_fail == 0, "R7", "no fail on short search", align_fail, 0);
    step(1);
    check(sample_valid == 8'hFF, "R9", "valid after align", sample_valid, 8'hFF);
  endtask

  task automatic t_interleave();
    logic [15:0] pats [3] = '{16'hA5C4, 16'hFFFC, 16'h5554};
    for (int p = 0; p < 3; p++) begin
      bit ok = 1;
      logic [15:0] bad_a = 0, bad_e = 0;
      for (int ch = 0; ch < 8; ch++) smp[ch] = pats[p] ^ (16'h1234 * 16'(ch));
      step(2);
      for (int ch = 0; ch < 8; ch++) begin
        logic [15:0] e = {smp[ch][15:2], 2'b00};
        if (sample_words[ch*16 +: 16] !== e) begin
          ok = 0; bad_a = sample_words[ch*16 +: 16]; bad_e = e;
        end
      end
      check(ok, "R1", "interleaved sample", bad_a, bad_e);
    end
  endtask

  task automatic t_lsb_zero();
    junk_lsb = 1;
    for (int ch = 0; ch < 8; ch++) smp[ch] = 16'hFFFF;
    step(2);
    check(sample_words[1:0] == 0 && sample_words[113:112] == 0, "R2",
          "pad bits with lane bit0 set", sample_words[15:0], 16'hFFFC);
    junk_lsb = 0;
  endtask

  task automatic t_concurrent();
    bit b_ok = 1, a_ok = 1;
    clear_mon();
    for (int ch = 0; ch < 8; ch++) smp[ch] = 16'h3C3C + 16'(ch * 4);
    step(2);
    off[0] = (off[0] + 3) % 8;   // boundary jump on A without a slip
    step(1);
    check(aligned == 2'b10, "R8", "A drops one cycle after mismatch", aligned, 2);
    step(1);
    for (int ch = 0; ch < 8; ch++)
      if (dom_of(ch) == 0 && sample_valid[ch]) a_ok = 0;
    check(a_ok, "R9", "A channels invalid after loss", sample_valid, 8'h66);
    for (int i = 0; i < 60; i++) begin
      for (int ch = 0; ch < 8; ch++)
        if (dom_of(ch) == 1 && (!sample_valid[ch] ||
            sample_words[ch*16 +: 16] !== {smp[ch][15:2], 2'b00})) b_ok = 0;
      if (slip_req[1]) b_ok = 0;
      step(1);
    end
    check(b_ok, "R6", "B valid and unchanged while A slips", slips_seen[1], 0);
    check(aligned[0] && slips_seen[0] == 5, "R8", "A re-search slip count",
          slips_seen[0], 5);
  endtask

  task automatic t_fail();
    int n = 0;
    clear_mon();
    stuck[1] = 1;
    for (int i = 0; i < 200 && !align_fail[1]; i++) step(1);
    n = slips_seen[1];
    check(align_fail[1] && slip_req[1] && n == 8, "R7", "fail with 8th slip", n, 8);
    step(40);
    check(slips_seen[1] > 8 && align_fail[1], "R7", "retry continues",
          slips_seen[1], 9);
    check(aligned[0] && slips_seen[0] == 0, "R6", "A unaffected by B failure",
          slips_seen[0], 0);
    stuck[1] = 0;
    wait_aligned(1, 200);
    check(aligned[1] && !align_fail[1], "R7", "fail clears on align",
          {aligned[1], align_fail[1]}, 2);
  endtask

  initial begin
    off[0] = 0; off[1] = 0; stuck[0] = 0; stuck[1] = 0;
    for (int ch = 0; ch < 8; ch++) smp[ch] = 16'h0;
    clear_mon();
    t_reset();
    t_hold_unlocked();
    t_initial_align();
    t_interleave();
    t_lsb_zero();
    t_concurrent();
    t_fail();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule